// File: doc/BRIEF.md
# Approximate Compressor-Tree Unsigned Multiplier

This block multiplies two 8-bit unsigned operands into a 16-bit product without any clock or storage. Every operand-bit pair is ANDed into a partial-product matrix. A column-by-column compressor tree then squeezes that matrix down to two rows, and one carry-propagate adder sums the two rows. The tree can trade accuracy for area: in the approximate columns it uses 4-2 compressors that have no carry-in and no carry-out.

There are two kinds of these cheap compressors. The plain one reports a sum of 1 when all four of its inputs are zero, which is the input pattern that partial products produce most often. The repaired one adds a small recovery term, so that an all-zero input gives zero on both outputs. The build-time parameter `MODE` picks the arrangement. `AM_EXACT` (0) is an exact reference. `AM_CN` (1) makes only the lower half of the columns approximate. `AM_CFULL` (2) makes every column approximate. A design chooses one arrangement per instance, according to the error budget of the image or signal path that uses it.

Top module: `amul_top`

## Requirements
- R1: The partial product for operand bits a[i] and b[k] is a[i]&b[k], and it carries weight 2^(i+k). Each column j starts as an ordered bit list that holds these bits in ascending order of i.
- R2: Columns are reduced from j=0 upward. A cell takes its inputs from the head of the column list, in the order X1, X2, X3, X4, then Cin. Its sum is appended to the tail of the same list. Its outputs for column j+1 are appended to that list in the order Carry, then Cout. A column stops being reduced once it holds at most two bits.
- R3: The exact 4-2 cell satisfies X1+X2+X3+X4+Cin = Sum + 2*(Carry+Cout), with Cout = majority(X1,X2,X3), so Cout does not depend on Cin. The full adder and the half adder are the usual exact cells.
- R4: The plain approximate cell gives Carry = (X1|X2)&(X3|X4). Its Sum is 0 exactly when X1^X2 and X3^X4 are both 1, and 1 for every other input.
- R5: The repaired approximate cell gives the same Carry and Sum = (X1&X2 | X3&X4 | ~Carry) & (X1|X2|X3|X4). It therefore matches the plain cell except for input 0000, where both outputs are 0.
- R6: With MODE=0 every column uses an exact 4-2 cell while five or more bits remain, and a full adder while three or four remain.
- R7: With MODE=1, columns 0..7 use an approximate cell while four or more bits remain and a half adder while three remain. Column 7 uses the repaired cell and columns 0..6 use the plain cell. Columns 8 and up follow the exact rule of R6.
- R8: With MODE=2, every column follows the approximate rule of R7. Columns 8 and up use the repaired cell and columns 0..7 use the plain cell.
- R9: The product is the sum of the two remaining rows modulo 2^16. Bits that a cell sends to weight 2^16 are dropped.
- R10: With MODE=0 the product equals a*b for all 65536 operand pairs.
- R11: Over all operand pairs, MODE=2 gives a nonzero number of wrong products, and its total absolute error is never below that of MODE=0. For example, 0*0 gives a nonzero product, because the plain cell in column 3 sees 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Multiplicand, unsigned |
| b | input | 8 | Multiplier, unsigned |
| product | output | 16 | Product, exact or approximate depending on MODE |

## Verification
All results are purely combinational, so the product belongs to the same clock period in which the operands change. There is no register between the ports, so no result has any cycle of latency. The bench changes the operands just after a rising edge of its own clock and reads all three instances, one per mode, at the following falling edge. By then every path has settled, and no read can race a write.

// File: rtl/amul_pkg.sv
package amul_pkg;

  typedef enum logic [1:0] {
    AM_EXACT = 2'd0,
    AM_CN    = 2'd1,
    AM_CFULL = 2'd2
  } am_mode_e;

  typedef enum logic [2:0] {
    K_EX,
    K_FA,
    K_HA,
    K_CONV,
    K_RCV
  } am_cell_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // returns {cout, carry, sum}; cout depends only on x1..x3
  function automatic logic [2:0] exact42(input logic x1, input logic x2,
                                         input logic x3, input logic x4,
                                         input logic cin);
    logic s1;
    logic co;
    s1 = x1 ^ x2 ^ x3;
    co = maj3(x1, x2, x3);
    return {co, maj3(s1, x4, cin), s1 ^ x4 ^ cin};
  endfunction

  // returns {carry, sum}
  function automatic logic [1:0] conv42(input logic x1, input logic x2,
                                        input logic x3, input logic x4);
    return {(x1 | x2) & (x3 | x4), ~((x1 ^ x2) & (x3 ^ x4))};
  endfunction

  // returns {carry, sum}; all-zero input yields zero sum
  function automatic logic [1:0] rcv42(input logic x1, input logic x2,
                                       input logic x3, input logic x4);
    logic cy;
    cy = (x1 | x2) & (x3 | x4);
    return {cy, ((x1 & x2) | (x3 & x4) | ~cy) & (x1 | x2 | x3 | x4)};
  endfunction

  function automatic logic [1:0] fadd(input logic x, input logic y, input logic z);
    return {maj3(x, y, z), x ^ y ^ z};
  endfunction

  function automatic logic [1:0] hadd(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  // cell choice for a column with 'left' bits still pending
  function automatic am_cell_e pick_cell(input am_mode_e md, input int col,
                                         input int w, input int left);
    logic apx;
    apx = (md == AM_CFULL) || (md == AM_CN && col < w);
    if (!apx) return (left >= 5) ? K_EX : K_FA;
    if (left < 4) return K_HA;
    if ((md == AM_CN && col == w - 1) || (md == AM_CFULL && col >= w)) return K_RCV;
    return K_CONV;
  endfunction

endpackage

// File: rtl/amul_ppgen.sv
module amul_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  output logic [W-1:0][W-1:0]   pp
);

  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar k = 0; k < W; k++) begin : g_bit
      assign pp[i][k] = a[i] & b[k];
    end
  end

endmodule

// File: rtl/amul_tree.sv
module amul_tree
  import amul_pkg::*;
#(
  parameter int       W    = 8,
  parameter am_mode_e MODE = AM_CFULL
) (
  input  logic [W-1:0][W-1:0] pp,
  output logic [2*W-1:0]      row0,
  output logic [2*W-1:0]      row1
);

  localparam int NC = 2 * W;      // kept columns
  localparam int QD = 4 * W + 4;  // per-column list depth, sums included

  function automatic logic [2*NC-1:0] reduce(input logic [W-1:0][W-1:0] m);
    logic       q  [NC+1][QD];
    int         tl [NC+1];
    int         hd;
    logic [NC-1:0] r0;
    logic [NC-1:0] r1;
    logic [2:0] e;
    logic [1:0] c;
    for (int j = 0; j <= NC; j++) begin
      tl[j] = 0;
      for (int k = 0; k < QD; k++) q[j][k] = 1'b0;
    end
    for (int j = 0; j < NC; j++) begin
      for (int i = 0; i < W; i++) begin
        if (j - i >= 0 && j - i < W) begin
          q[j][tl[j]] = m[i][j-i];
          tl[j] = tl[j] + 1;
        end
      end
    end
    r0 = '0;
    r1 = '0;
    for (int j = 0; j < NC; j++) begin
      hd = 0;
      while (tl[j] - hd > 2) begin
        case (pick_cell(MODE, j, W, tl[j] - hd))
          K_EX: begin
            e = exact42(q[j][hd], q[j][hd+1], q[j][hd+2], q[j][hd+3], q[j][hd+4]);
            hd = hd + 5;
            q[j][tl[j]] = e[0];
            tl[j] = tl[j] + 1;
            q[j+1][tl[j+1]]   = e[1];
            q[j+1][tl[j+1]+1] = e[2];
            tl[j+1] = tl[j+1] + 2;
          end
          K_FA: begin
            c = fadd(q[j][hd], q[j][hd+1], q[j][hd+2]);
            hd = hd + 3;
            q[j][tl[j]] = c[0];
            tl[j] = tl[j] + 1;
            q[j+1][tl[j+1]] = c[1];
            tl[j+1] = tl[j+1] + 1;
          end
          K_HA: begin
            c = hadd(q[j][hd], q[j][hd+1]);
            hd = hd + 2;
            q[j][tl[j]] = c[0];
            tl[j] = tl[j] + 1;
            q[j+1][tl[j+1]] = c[1];
            tl[j+1] = tl[j+1] + 1;
          end
          K_CONV, K_RCV: begin
            if (pick_cell(MODE, j, W, tl[j] - hd) == K_RCV)
              c = rcv42(q[j][hd], q[j][hd+1], q[j][hd+2], q[j][hd+3]);
            else
              c = conv42(q[j][hd], q[j][hd+1], q[j][hd+2], q[j][hd+3]);
            hd = hd + 4;
            q[j][tl[j]] = c[0];
            tl[j] = tl[j] + 1;
            q[j+1][tl[j+1]] = c[1];
            tl[j+1] = tl[j+1] + 1;
          end
          default: hd = tl[j];
        endcase
      end
      if (tl[j] - hd >= 1) r0[j] = q[j][hd];
      if (tl[j] - hd >= 2) r1[j] = q[j][hd+1];
    end
    return {r1, r0};
  endfunction

  always_comb begin
    {row1, row0} = reduce(pp);
  end

endmodule

// File: rtl/amul_cpa.sv
module amul_cpa #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] s
);

  assign s = x + y;

endmodule

// File: rtl/amul_top.sv
module amul_top
  import amul_pkg::*;
#(
  parameter int       W    = 8,
  parameter am_mode_e MODE = AM_CFULL
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [W-1:0][W-1:0] pp;
  logic [PW-1:0]       row0;
  logic [PW-1:0]       row1;

  amul_ppgen #(.W(W)) u_pp (
    .a  (a),
    .b  (b),
    .pp (pp)
  );

  amul_tree #(.W(W), .MODE(MODE)) u_tree (
    .pp   (pp),
    .row0 (row0),
    .row1 (row1)
  );

  amul_cpa #(.PW(PW)) u_cpa (
    .x (row0),
    .y (row1),
    .s (product)
  );

endmodule

// File: rtl/amul_chk.sv
module amul_chk
  import amul_pkg::*;
#(
  parameter int       W    = 8,
  parameter am_mode_e MODE = AM_CFULL
) (
  input logic [W-1:0]          a,
  input logic [W-1:0]          b,
  input logic [W-1:0][W-1:0]   pp,
  input logic [2*W-1:0]        row0,
  input logic [2*W-1:0]        row1,
  input logic [2*W-1:0]        product
);

  localparam int PW = 2 * W;

  logic [PW-1:0] pp_weight;

  always_comb begin
    pp_weight = '0;
    for (int i = 0; i < W; i++)
      for (int k = 0; k < W; k++)
        pp_weight = pp_weight + (PW'(pp[i][k]) << (i + k));
  end

  always_comb begin
    if (!$isunknown({a, b, pp, row0, row1, product})) begin
      // R9
      cpa_sum_chk: assert (product == row0 + row1)
        else $error("final adder result disagrees with tree rows");
      for (int i = 0; i < W; i++) begin
        // R1
        pp_row_chk: assert ($countones(pp[i]) == (a[i] ? $countones(b) : 0))
          else $error("partial product row %0d malformed", i);
      end
      if (MODE == AM_EXACT) begin
        // R10
        exact_product_chk: assert (product == PW'(a) * PW'(b))
          else $error("exact mode product wrong");
        // R6
        exact_tree_keep_chk: assert (PW'(row0 + row1) == pp_weight)
          else $error("exact tree lost weight");
      end
    end
  end

endmodule

bind amul_top amul_chk #(.W(W), .MODE(MODE)) u_chk (
  .a       (a),
  .b       (b),
  .pp      (pp),
  .row0    (row0),
  .row1    (row1),
  .product (product)
);

// File: tb/amul_top_test.sv
`timescale 1ns/1ps
module amul_top_test;
  import amul_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  a = 8'd0;
  logic [7:0]  b = 8'd0;
  logic [15:0] p_ex;
  logic [15:0] p_cn;
  logic [15:0] p_cf;

  amul_top #(.W(8), .MODE(AM_CFULL)) uut    (.a(a), .b(b), .product(p_cf));
  amul_top #(.W(8), .MODE(AM_CN))    uut_cn (.a(a), .b(b), .product(p_cn));
  amul_top #(.W(8), .MODE(AM_EXACT)) uut_ex (.a(a), .b(b), .product(p_ex));

  int      checks = 0;
  int      errors = 0;
  bit      done   = 0;
  longint  ed_sum [3];
  int      miss   [3];

  // independent column-queue model; md: 0 exact, 1 low-half approx, 2 all approx
  function automatic bit [15:0] ref_mul(input bit [7:0] x, input bit [7:0] y, input int md);
    bit cq [17][$];
    bit [15:0] ra;
    bit [15:0] rb;
    bit v1, v2, v3, v4, v5, sm, cy, co;
    bit apx, fix;
    int t, u;
    bit [3:0] pat;
    ra = '0;
    rb = '0;
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 8; i++)
        if (c - i >= 0 && c - i < 8) cq[c].push_back(x[i] & y[c-i]);
    for (int c = 0; c < 16; c++) begin
      apx = (md == 2) || (md == 1 && c < 8);
      fix = (md == 2 && c >= 8) || (md == 1 && c == 7);
      while (cq[c].size() > 2) begin
        if (apx && cq[c].size() >= 4) begin
          v1 = cq[c].pop_front(); v2 = cq[c].pop_front();
          v3 = cq[c].pop_front(); v4 = cq[c].pop_front();
          pat = {v4, v3, v2, v1};
          cy = (v1 | v2) & (v3 | v4);
          sm = !(pat == 4'd5 || pat == 4'd6 || pat == 4'd9 || pat == 4'd10);
          if (fix && pat == 4'd0) sm = 1'b0;
          cq[c].push_back(sm);
          cq[c+1].push_back(cy);
        end else if (apx) begin
          v1 = cq[c].pop_front(); v2 = cq[c].pop_front();
          cq[c].push_back(v1 ^ v2);
          cq[c+1].push_back(v1 & v2);
        end else if (cq[c].size() >= 5) begin
          v1 = cq[c].pop_front(); v2 = cq[c].pop_front(); v3 = cq[c].pop_front();
          v4 = cq[c].pop_front(); v5 = cq[c].pop_front();
          t  = int'(v1) + int'(v2) + int'(v3);
          co = (t >= 2);
          u  = (t % 2) + int'(v4) + int'(v5);
          cq[c].push_back(u % 2 == 1);
          cq[c+1].push_back(u >= 2);
          cq[c+1].push_back(co);
        end else begin
          v1 = cq[c].pop_front(); v2 = cq[c].pop_front(); v3 = cq[c].pop_front();
          t = int'(v1) + int'(v2) + int'(v3);
          cq[c].push_back(t % 2 == 1);
          cq[c+1].push_back(t >= 2);
        end
      end
      if (cq[c].size() >= 1) ra[c] = cq[c][0];
      if (cq[c].size() == 2) rb[c] = cq[c][1];
    end
    return ra + rb;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tally(input int md, input logic [15:0] got, input logic [7:0] x, input logic [7:0] y);
    int d;
    d = int'(got) - int'(x) * int'(y);
    if (d < 0) d = -d;
    if (d != 0) miss[md]++;
    ed_sum[md] += d;
  endtask

  // operands change after a rising edge; results read at the next falling edge
  task automatic check_pair(input logic [7:0] x, input logic [7:0] y, input string req);
    @(posedge clk);
    #1;
    a = x;
    b = y;
    @(negedge clk);
    cmp(req, "exact-model", p_ex, ref_mul(x, y, 0));
    cmp({req, " R10"}, "exact-true", p_ex, 16'(x) * 16'(y));
    cmp(req, "low-half", p_cn, ref_mul(x, y, 1));
    cmp(req, "all-approx", p_cf, ref_mul(x, y, 2));
    tally(0, p_ex, x, y);
    tally(1, p_cn, x, y);
    tally(2, p_cf, x, y);
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      ed_sum[m] = 0;
      miss[m]   = 0;
    end
    // R4 R5: all-zero compressor inputs in both approximate modes
    check_pair(8'h00, 8'h00, "R4/R5 zero operands");
    // R3 R6: tallest columns, every exact cell busy
    check_pair(8'hff, 8'hff, "R3/R6 full scale");
    // R1 R9: single partial product
    check_pair(8'h01, 8'h01, "R1/R9 unit");
    check_pair(8'h80, 8'h80, "R9 top weight");
    // R7 R8: low and high halves lit differently
    check_pair(8'h0f, 8'hf0, "R7/R8 split nibbles");
    check_pair(8'hf0, 8'h0f, "R7/R8 swapped nibbles");
    check_pair(8'haa, 8'h55, "R2 alternating bits");
    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++)
      check_pair(8'($urandom()), 8'($urandom()), "R2/R7/R8 random");
    // R11: exhaustive sweep of all pairs
    for (int n = 0; n < 65536; n++)
      check_pair(n[15:8], n[7:0], "R11 sweep");
    cmp("R10", "exact mismatch count", 16'(miss[0]), 16'd0);
    checks++;
    if (miss[2] == 0 || ed_sum[2] < ed_sum[0]) begin
      errors++;
      $display("FAIL R11 all-approx error stats got miss %0d sum %0d expected miss>0 sum>=%0d",
               miss[2], ed_sum[2], ed_sum[0]);
    end
    $display("error tallies: exact %0d/%0d low-half %0d/%0d all-approx %0d/%0d",
             miss[0], ed_sum[0], miss[1], ed_sum[1], miss[2], ed_sum[2]);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog got timeout expected sweep completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule